// File: doc/BRIEF.md
# Serial EEPROM Write-Path Slave

This block is the slave side of the write path of a serial EEPROM on an SPI bus. It runs on a fast system clock. It synchronises chip select, the serial clock and the serial input, and reacts to the serial clock's edges. It decodes a command byte and keeps a write-enable flag. For a write it takes a 16-bit address and collects data bytes into a page buffer. When chip select rises on a byte boundary, it starts a timed programming cycle that copies the loaded bytes into the byte array.

While programming runs, the block ignores every command except the status read. The status read returns a busy flag and the write-enable flag. When programming ends, the write-enable flag clears by itself. The array has its own read port, which lets the neighbouring read logic see the stored bytes.

Top module: `spi_ee_writer`

## Requirements
- R1: The command byte 0x06 (enable), sent while the block is idle, sets the write-enable flag. The flag reads back as status bit 1.
- R2: A write command (0x02) sent while the write-enable flag is clear leaves the array and the status unchanged.
- R3: The write address is 16 bits sent MSB first. Only its low 11 bits pick the byte, and the upper 5 bits have no effect.
- R4: Each data byte goes to the current column of the page and then moves the low 5 address bits up by one, wrapping from 31 to 0. The page bits do not change, and a later byte overwrites an earlier one at the same column.
- R5: Programming starts only when chip select rises after at least one whole data byte. Status bit 0 reads 1 for PROG_CYCLES system clocks, and then the loaded bytes appear in the array.
- R6: While programming runs, the enable and write commands have no effect. The status read (0x05) still works.
- R7: When programming ends, the write-enable flag clears.
- R8: If chip select rises inside the address or partway through a data byte, no programming starts and the write-enable flag keeps its value.
- R9: The status read drives {6'b0, write-enable, busy} on SO, MSB first, changing on falling serial-clock edges. The SO enable is high only during that output.
- R10: Commands work with the serial clock idling low (mode 0) and idling high (mode 3).
- R11: After reset the status reads 0x00 and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in, sampled on rising sck |
| so | output | 1 | Serial data out for the status read |
| soOe | output | 1 | Output enable for so; high-impedance when low |
| arrRdAddr | input | ADDR_BITS | Array read address |
| arrRdData | output | 8 | Array byte at arrRdAddr |

## Verification
The bench builds the block with PROG_CYCLES = 1500. That is long enough to send an enable, a full write and a status read while a cycle is still running, so the busy behaviour and the ignored commands can be seen from the pins. The default 2048-byte array and 32-byte pages are kept. This puts page wrap on the last page and the discarded upper address bits within reach, and the whole array can be compared after every step.

// File: rtl/ee_wr_pkg.sv
package ee_wr_pkg;
  localparam logic [7:0] OP_ENABLE = 8'h06;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_STATUS = 8'h05;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DATA, ST_STAT, ST_SKIP
  } busState_t;

  typedef struct packed {
    logic       addrShift;
    logic       addrBit;
    logic       addrDone;
    logic       loadByte;
    logic [7:0] dataByte;
    logic       commit;
  } dpStrobe_t;
endpackage

// File: rtl/ee_wr_ctrl.sv
module ee_wr_ctrl
  import ee_wr_pkg::*;
#(
  parameter int PROG_CYCLES = 5000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sck,
  input  logic      si,
  output dpStrobe_t stb,
  output logic      so,
  output logic      soOe
);
  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic [1:0] csSync, sckSync, siSync;
  logic       csPrev, sckPrev;
  logic       csHi, sckNow, siNow;
  logic       csRise, csFall, sckRise, sckFall, byteEnd;
  logic [7:0] shifter, nextShift;
  logic [2:0] bitCnt, outCnt;
  logic       addrHi, gotByte, wel, busy;
  logic [TW-1:0] timer;
  busState_t  state;
  logic [7:0] statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync  <= 2'b11;
      sckSync <= 2'b00;
      siSync  <= 2'b00;
      csPrev  <= 1'b1;
      sckPrev <= 1'b0;
    end else begin
      csSync  <= {csSync[0], csN};
      sckSync <= {sckSync[0], sck};
      siSync  <= {siSync[0], si};
      csPrev  <= csSync[1];
      sckPrev <= sckSync[1];
    end
  end

  assign csHi      = csSync[1];
  assign sckNow    = sckSync[1];
  assign siNow     = siSync[1];
  assign csRise    = csHi & ~csPrev;
  assign csFall    = ~csHi & csPrev;
  assign sckRise   = ~csHi & sckNow & ~sckPrev;
  assign sckFall   = ~csHi & ~sckNow & sckPrev;
  assign nextShift = {shifter[6:0], siNow};
  assign byteEnd   = sckRise && (bitCnt == 3'd7);
  assign statusByte = {6'b0, wel, busy};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      shifter <= '0;
      bitCnt  <= '0;
      addrHi  <= 1'b0;
      gotByte <= 1'b0;
      wel     <= 1'b0;
      busy    <= 1'b0;
      timer   <= '0;
    end else begin
      if (busy) begin
        timer <= timer - 1'b1;
        if (timer == TW'(1)) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end
      end
      if (csRise) begin
        state <= ST_IDLE;
        if (state == ST_DATA && bitCnt == 3'd0 && gotByte) begin
          busy  <= 1'b1;
          timer <= TW'(PROG_CYCLES);
        end
      end else if (csFall) begin
        state   <= ST_CMD;
        bitCnt  <= '0;
        addrHi  <= 1'b0;
        gotByte <= 1'b0;
      end else if (sckRise) begin
        shifter <= nextShift;
        bitCnt  <= bitCnt + 1'b1;
        if (byteEnd) begin
          case (state)
            ST_CMD: begin
              if (nextShift == OP_STATUS)                 state <= ST_STAT;
              else if (busy)                              state <= ST_SKIP;
              else if (nextShift == OP_WRITE && wel)      state <= ST_ADDR;
              else begin
                state <= ST_SKIP;
                if (nextShift == OP_ENABLE) wel <= 1'b1;
              end
            end
            ST_ADDR: begin
              addrHi <= ~addrHi;
              if (addrHi) state <= ST_DATA;
            end
            ST_DATA: gotByte <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      so     <= 1'b0;
      outCnt <= '0;
    end else if (state != ST_STAT) begin
      outCnt <= '0;
    end else if (sckFall) begin
      so     <= statusByte[3'd7 - outCnt];
      outCnt <= outCnt + 1'b1;
    end
  end

  assign soOe = (state == ST_STAT);

  always_comb begin
    stb           = '0;
    stb.addrShift = sckRise && (state == ST_ADDR);
    stb.addrBit   = siNow;
    stb.addrDone  = byteEnd && (state == ST_ADDR) && addrHi;
    stb.loadByte  = byteEnd && (state == ST_DATA);
    stb.dataByte  = nextShift;
    stb.commit    = busy && (timer == TW'(1));
  end

  // R7: write-enable is gone once the busy flag drops
  a_r7_wel_cleared: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);
  // R5: busy starts only from a chip-select rise
  a_r5_start_on_cs: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise));
  // R6: no address or data loading while programming
  a_r6_no_load_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(state == ST_ADDR || state == ST_DATA));
  // R9: SO released after chip select goes high
  a_r9_so_released: assert property (@(posedge clk) disable iff (!rstN)
    csHi |=> !soOe);
endmodule

// File: rtl/ee_wr_data.sv
module ee_wr_data
  import ee_wr_pkg::*;
#(
  parameter int ADDR_BITS  = 11,
  parameter int PAGE_BYTES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            stb,
  input  logic [ADDR_BITS-1:0] rdAddr,
  output logic [7:0]           rdData
);
  localparam int COL_BITS  = $clog2(PAGE_BYTES);
  localparam int PAGE_BITS = ADDR_BITS - COL_BITS;
  localparam int DEPTH     = 1 << ADDR_BITS;

  logic [15:0]          addrReg, nextAddr;
  logic [COL_BITS-1:0]  col;
  logic [PAGE_BYTES-1:0] valid;
  logic [7:0]           pageBuf [PAGE_BYTES];
  logic [7:0]           mem [DEPTH];
  logic [PAGE_BITS-1:0] pageSel;

  assign nextAddr = {addrReg[14:0], stb.addrBit};
  assign pageSel  = addrReg[ADDR_BITS-1:COL_BITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      col     <= '0;
      valid   <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else begin
      if (stb.addrShift) addrReg <= nextAddr;
      if (stb.addrDone) begin
        col   <= nextAddr[COL_BITS-1:0];
        valid <= '0;
      end else if (stb.loadByte) begin
        pageBuf[col] <= stb.dataByte;
        valid[col]   <= 1'b1;
        col          <= col + 1'b1;
      end
      if (stb.commit) begin
        for (int i = 0; i < PAGE_BYTES; i++)
          if (valid[i]) mem[{pageSel, COL_BITS'(i)}] <= pageBuf[i];
      end
    end
  end

  assign rdData = mem[rdAddr];

  // R5: a commit only happens with at least one loaded byte
  a_r5_commit_has_data: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> (valid != '0));
  // R4: column steps by one modulo the page after each byte
  a_r4_col_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadByte && !stb.addrDone) |=> (col == COL_BITS'($past(col) + 1'b1)));
endmodule

// File: rtl/spi_ee_writer.sv
module spi_ee_writer
  import ee_wr_pkg::*;
#(
  parameter int ADDR_BITS   = 11,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 5000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 sck,
  input  logic                 si,
  output logic                 so,
  output logic                 soOe,
  input  logic [ADDR_BITS-1:0] arrRdAddr,
  output logic [7:0]           arrRdData
);
  dpStrobe_t stb;

  ee_wr_ctrl #(.PROG_CYCLES(PROG_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .stb(stb), .so(so), .soOe(soOe)
  );

  ee_wr_data #(.ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES)) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rdAddr(arrRdAddr), .rdData(arrRdData)
  );
endmodule

// File: tb/sim_spi_ee_writer.sv
module sim_spi_ee_writer;
  localparam int AB = 11;
  localparam int DEPTH = 1 << AB;
  localparam int PROG = 1500;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, soOe;
  logic [AB-1:0] arrRdAddr = '0;
  logic [7:0] arrRdData;
  logic mode3 = 1'b0;
  logic [7:0] model [DEPTH];
  int checks = 0, bad = 0;
  int csHighCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_ee_writer #(.ADDR_BITS(AB), .PAGE_BYTES(32), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .so(so), .soOe(soOe), .arrRdAddr(arrRdAddr), .arrRdData(arrRdData)
  );

  // R9: every clock, SO enable must be low once chip select has been high a while
  always @(negedge clk) begin
    if (csN) csHighCnt <= csHighCnt + 1; else csHighCnt <= 0;
    if (rstN && csN && csHighCnt > 4 && soOe) begin
      bad++;
      $display("FAIL R9: soOe=%0b with chip select high, expected 0", soOe);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (H) @(negedge clk);
  endtask

  task automatic csLow();
    sck = mode3;
    halfWait();
    csN = 1'b0;
    halfWait();
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sck = 1'b0; si = v[i];
      halfWait();
      sck = 1'b1;
      halfWait();
    end
  endtask

  task automatic csHigh();
    if (!mode3) sck = 1'b0;
    halfWait();
    csN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic readStatus(output logic [7:0] st);
    st = '0;
    csLow();
    sendBits(32'h05, 8);
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0;
      halfWait();
      st = {st[6:0], so};
      if (!soOe) begin bad++; $display("FAIL R9: soOe=0 during status, expected 1"); end
      sck = 1'b1;
      halfWait();
    end
    csHigh();
  endtask

  task automatic checkStatus(input logic [7:0] exp, input string tag);
    logic [7:0] st;
    readStatus(st);
    check(st === exp, tag, st, exp);
  endtask

  task automatic enable();
    csLow(); sendBits(32'h06, 8); csHigh();
  endtask

  task automatic doWrite(input logic [15:0] addr, input logic [7:0] q[$], input int extra);
    csLow();
    sendBits(32'h02, 8);
    sendBits({16'h0, addr}, 16);
    foreach (q[i]) sendBits({24'h0, q[i]}, 8);
    if (extra > 0) sendBits(32'h0, extra);
    csHigh();
  endtask

  task automatic modelPage(input logic [15:0] addr, input logic [7:0] q[$]);
    int col = addr[4:0];
    int pg = addr[10:5];
    foreach (q[i]) begin
      model[pg * 32 + col] = q[i];
      col = (col + 1) % 32;
    end
  endtask

  task automatic checkMem(input string tag);
    int firstBad = -1;
    logic [7:0] act = '0;
    for (int a = 0; a < DEPTH; a++) begin
      arrRdAddr = AB'(a);
      #0.1;
      if (arrRdData !== model[a] && firstBad < 0) begin firstBad = a; act = arrRdData; end
    end
    if (firstBad < 0) check(1'b1, tag, 0, 0);
    else begin
      $display("FAIL %s: byte %0h actual=%0h expected=%0h", tag, firstBad, act, model[firstBad]);
      checks++; bad++;
    end
  endtask

  task automatic waitProg();
    repeat (PROG + 100) @(negedge clk);
  endtask

  initial begin
    logic [7:0] q[$];
    for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    check(soOe === 1'b0, "R9 reset soOe", soOe, 0);
    checkStatus(8'h00, "R11 reset status");
    checkMem("R11 reset array");

    // R2: write without enable
    q = '{8'hAA};
    doWrite(16'h0040, q, 0);
    checkStatus(8'h00, "R2 status after unenabled write");
    waitProg();
    checkMem("R2 array unchanged");

    // R1: enable sets bit 1
    enable();
    checkStatus(8'h02, "R1 enable flag");

    // R3/R5/R7: single byte with junk upper address bits
    q = '{8'h5A};
    doWrite(16'hF813, q, 0);
    checkStatus(8'h03, "R5 busy during programming");
    waitProg();
    checkStatus(8'h00, "R7 flag cleared after programming");
    modelPage(16'h0013, q);
    checkMem("R3 upper address bits ignored");

    // R4: 34 bytes from column 30 of page 5 wrap and overwrite
    enable();
    q = {};
    for (int i = 0; i < 34; i++) q.push_back(8'(i * 3 + 1));
    doWrite(16'h00BE, q, 0);
    waitProg();
    modelPage(16'h00BE, q);
    checkMem("R4 page wrap and overwrite");

    // R6: commands during programming
    enable();
    q = '{8'h11, 8'h22};
    doWrite(16'h0123, q, 0);
    enable();
    doWrite(16'h0300, '{8'h77}, 0);
    checkStatus(8'h03, "R6 status read while busy");
    waitProg();
    checkStatus(8'h00, "R6 enable during busy ignored");
    modelPage(16'h0123, q);
    checkMem("R6 write during busy ignored");

    // R8: partial data byte
    enable();
    doWrite(16'h0200, '{8'h99}, 4);
    checkStatus(8'h02, "R8 partial byte no programming");
    waitProg();
    checkMem("R8 partial byte array unchanged");

    // R8: chip select rises inside the address
    csLow(); sendBits(32'h02, 8); sendBits(32'h03, 8); csHigh();
    checkStatus(8'h02, "R8 address abort keeps flag");

    // R10: mode 3, wrap on the last page
    mode3 = 1'b1;
    q = '{8'hC3, 8'h3C};
    doWrite(16'h07FF, q, 0);
    checkStatus(8'h03, "R10 mode 3 busy");
    waitProg();
    checkStatus(8'h00, "R10 mode 3 done");
    modelPage(16'h07FF, q);
    checkMem("R10 mode 3 array");
    mode3 = 1'b0;

    checks++; // per-clock SO enable monitor (R9)
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule